// File: doc/BRIEF.md
# Shared Pipelined Radix-4 Integer Divider

This block is one 32-bit integer divider serving two requesting cores. Each core has its own valid/ready request port carrying a dividend, a divisor, a signed/unsigned select and a small tag. The datapath is fully pipelined. Every stage retires two quotient bits with a radix-4 restoring step, so a new divide can enter on any clock.

The block arbitrates between the cores by cycle parity alone. Each core owns every other clock. An accepted request sits in a one-entry hold register until its core's next slot, which is never more than one cycle away. As a result, the latency one core sees is set only by the phase of its own acceptance edge. The other core's traffic has no effect on it, so the shared unit cannot be used as a timing side channel between the cores.

Results leave on a single output port. Each result carries the number of the core that asked for it and the tag that came with the request. Signed operands are converted to magnitudes on entry, and the result signs are corrected on exit.

Top module: `div_shared_top`

## Requirements
- R1: In unsigned mode with a nonzero divisor, `res_quot` is floor(dividend/divisor) and `res_rem` is the dividend minus quotient×divisor. Both are 32-bit unsigned values.
- R2: In signed mode with a nonzero divisor, other than the case in R4, the quotient is rounded toward zero. The remainder takes the sign of the dividend, and its magnitude is less than the magnitude of the divisor.
- R3: A zero divisor, in either mode, returns a quotient of all ones and a remainder equal to the dividend bit for bit.
- R4: In signed mode, 0x80000000 divided by 0xFFFFFFFF returns a quotient of 0x80000000 and a remainder of 0.
- R5: Every result carries `res_core` = 0 for requests from port a and 1 for requests from port b, together with the request's tag. Results for one core return in the order that core's requests were accepted.
- R6: A request accepted on a rising edge k produces its result on edge k+18 or on edge k+19. Which of the two depends only on the requesting core and the parity of k, never on the other core's activity.
- R7: All results for one core appear on edges of a single parity, and the two cores use opposite parities. When results appear on two consecutive cycles, they therefore come from different cores.
- R8: A held request waits at most one cycle before entering the pipeline. A core that presents requests back to back has one accepted every two cycles once its first request is held.
- R9: While reset is applied and just after it is released, `res_valid` is 0 and both ready outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_valid | input | 1 | Core 0 request valid |
| a_ready | output | 1 | Core 0 request can be taken this cycle |
| a_dividend | input | 32 | Core 0 dividend |
| a_divisor | input | 32 | Core 0 divisor |
| a_signed | input | 1 | Core 0: 1 = two's-complement operands |
| a_tag | input | 4 | Core 0 request tag |
| b_valid | input | 1 | Core 1 request valid |
| b_ready | output | 1 | Core 1 request can be taken this cycle |
| b_dividend | input | 32 | Core 1 dividend |
| b_divisor | input | 32 | Core 1 divisor |
| b_signed | input | 1 | Core 1: 1 = two's-complement operands |
| b_tag | input | 4 | Core 1 request tag |
| res_valid | output | 1 | Result valid this cycle |
| res_core | output | 1 | Core that issued the request (0 = a, 1 = b) |
| res_tag | output | 4 | Tag of the request |
| res_quot | output | 32 | Quotient |
| res_rem | output | 32 | Remainder |

## Verification
Directed operands cover the special cases:
- Unsigned operands with the top bit set separate a true unsigned recurrence from a signed one.
- The four sign combinations in signed mode separate the rules for quotient and remainder signs.
- Zero divisors in both modes, and the most-negative value divided by minus one, exercise the overrides and the overflow case.

Random operands, with small divisors and zero divisors mixed in, run on both cores with random gaps between requests. Because the contention pattern keeps changing, a latency that drifts with the other core's load shows up as a mismatch against the latency each core first showed for a given acceptance parity. A back-to-back burst from one core tells apart a hold register that frees in time from one that stalls the core.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int DEF_DW = 32;
  localparam int DEF_TW = 4;
  typedef enum logic {CORE_A = 1'b0, CORE_B = 1'b1} core_e;
endpackage

// File: rtl/div_hold.sv
module div_hold #(
  parameter int DW = 32,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_n,
  input  logic [DW-1:0] in_d,
  input  logic          in_sgn,
  input  logic [TW-1:0] in_tag,
  input  logic          own_slot,
  output logic          held,
  output logic          issue,
  output logic [DW-1:0] out_n,
  output logic [DW-1:0] out_d,
  output logic          out_sgn,
  output logic [TW-1:0] out_tag
);
  assign issue    = held & own_slot;
  assign in_ready = ~held | issue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= 1'b0;
      out_n   <= '0;
      out_d   <= '0;
      out_sgn <= 1'b0;
      out_tag <= '0;
    end else if (in_valid && in_ready) begin
      held    <= 1'b1;
      out_n   <= in_n;
      out_d   <= in_d;
      out_sgn <= in_sgn;
      out_tag <= in_tag;
    end else if (issue) begin
      held <= 1'b0;
    end
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int DW  = 32,
  parameter int SBW = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SBW-1:0] i_sb,
  input  logic [DW-1:0]  i_rem,
  input  logic [DW-1:0]  i_q,
  input  logic [DW-1:0]  i_d,
  output logic [SBW-1:0] o_sb,
  output logic [DW-1:0]  o_rem,
  output logic [DW-1:0]  o_q,
  output logic [DW-1:0]  o_d
);
  localparam int PW = DW + 2;

  function automatic logic [1:0] pick_digit(input logic [PW-1:0] part,
                                            input logic [DW-1:0] dv);
    logic [PW-1:0] d1, d2, d3;
    d1 = {2'b00, dv};
    d2 = {1'b0, dv, 1'b0};
    d3 = d1 + d2;
    if (part >= d3)      return 2'd3;
    else if (part >= d2) return 2'd2;
    else if (part >= d1) return 2'd1;
    else                 return 2'd0;
  endfunction

  function automatic logic [PW-1:0] digit_times(input logic [1:0] dg,
                                                input logic [DW-1:0] dv);
    logic [PW-1:0] d1, d2;
    d1 = {2'b00, dv};
    d2 = {1'b0, dv, 1'b0};
    case (dg)
      2'd0:    return '0;
      2'd1:    return d1;
      2'd2:    return d2;
      default: return d1 + d2;
    endcase
  endfunction

  logic [PW-1:0] part, diff;
  logic [1:0]    dig;

  always_comb begin
    part = {i_rem, i_q[DW-1 -: 2]};
    dig  = pick_digit(part, i_d);
    diff = part - digit_times(dig, i_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_sb  <= '0;
      o_rem <= '0;
      o_q   <= '0;
      o_d   <= '0;
    end else begin
      o_sb  <= i_sb;
      o_rem <= diff[DW-1:0];
      o_q   <= {i_q[DW-3:0], dig};
      o_d   <= i_d;
    end
  end
endmodule

// File: rtl/div_shared_top.sv
module div_shared_top #(
  parameter int DW = div_pkg::DEF_DW,
  parameter int TW = div_pkg::DEF_TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_valid,
  output logic          a_ready,
  input  logic [DW-1:0] a_dividend,
  input  logic [DW-1:0] a_divisor,
  input  logic          a_signed,
  input  logic [TW-1:0] a_tag,
  input  logic          b_valid,
  output logic          b_ready,
  input  logic [DW-1:0] b_dividend,
  input  logic [DW-1:0] b_divisor,
  input  logic          b_signed,
  input  logic [TW-1:0] b_tag,
  output logic          res_valid,
  output logic          res_core,
  output logic [TW-1:0] res_tag,
  output logic [DW-1:0] res_quot,
  output logic [DW-1:0] res_rem
);
  localparam int NSTG = DW / 2;
  localparam int SBW  = TW + 5;
  localparam int SB_V = SBW - 1;
  localparam int SB_C = SBW - 2;
  localparam int SB_T = SBW - 3;

  // slot owner: core a on even phase, core b on odd phase
  logic par;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par <= 1'b0;
    else        par <= ~par;
  end

  logic [1:0]    rq_v, rq_rdy, hold_v, iss, h_sgn;
  logic [DW-1:0] rq_n [2];
  logic [DW-1:0] rq_d [2];
  logic [TW-1:0] rq_t [2];
  logic [DW-1:0] h_n  [2];
  logic [DW-1:0] h_d  [2];
  logic [TW-1:0] h_t  [2];
  logic [1:0]    rq_s;

  assign rq_v    = {b_valid, a_valid};
  assign rq_s    = {b_signed, a_signed};
  assign rq_n[0] = a_dividend;
  assign rq_n[1] = b_dividend;
  assign rq_d[0] = a_divisor;
  assign rq_d[1] = b_divisor;
  assign rq_t[0] = a_tag;
  assign rq_t[1] = b_tag;
  assign a_ready = rq_rdy[0];
  assign b_ready = rq_rdy[1];

  for (genvar g = 0; g < 2; g++) begin : g_hold
    div_hold #(.DW(DW), .TW(TW)) u_hold (
      .clk(clk), .rst_n(rst_n),
      .in_valid(rq_v[g]), .in_ready(rq_rdy[g]),
      .in_n(rq_n[g]), .in_d(rq_d[g]), .in_sgn(rq_s[g]), .in_tag(rq_t[g]),
      .own_slot(par == 1'(g)),
      .held(hold_v[g]), .issue(iss[g]),
      .out_n(h_n[g]), .out_d(h_d[g]), .out_sgn(h_sgn[g]), .out_tag(h_t[g])
    );
  end

  function automatic logic [DW-1:0] magnitude(input logic [DW-1:0] x,
                                              input logic neg);
    return neg ? (~x + 1'b1) : x;
  endfunction

  function automatic logic [DW-1:0] fix_quot(input logic [DW-1:0] q,
                                             input logic neg, input logic dz);
    if (dz) return '1;
    return neg ? (~q + 1'b1) : q;
  endfunction

  // issue mux and operand preparation
  logic          sel;
  logic          ng_n, ng_d;
  logic [SBW-1:0] in_sb;
  assign sel  = iss[1];
  assign ng_n = h_sgn[sel] & h_n[sel][DW-1];
  assign ng_d = h_sgn[sel] & h_d[sel][DW-1];
  assign in_sb = {|iss, sel, h_t[sel], ng_n ^ ng_d, ng_n, h_d[sel] == '0};

  logic [SBW-1:0] st_sb  [NSTG+1];
  logic [DW-1:0]  st_rem [NSTG+1];
  logic [DW-1:0]  st_q   [NSTG+1];
  logic [DW-1:0]  st_d   [NSTG+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_sb[0]  <= '0;
      st_rem[0] <= '0;
      st_q[0]   <= '0;
      st_d[0]   <= '0;
    end else begin
      st_sb[0]  <= in_sb;
      st_rem[0] <= '0;
      st_q[0]   <= magnitude(h_n[sel], ng_n);
      st_d[0]   <= magnitude(h_d[sel], ng_d);
    end
  end

  for (genvar s = 1; s <= NSTG; s++) begin : g_stage
    div_step #(.DW(DW), .SBW(SBW)) u_step (
      .clk(clk), .rst_n(rst_n),
      .i_sb(st_sb[s-1]), .i_rem(st_rem[s-1]), .i_q(st_q[s-1]), .i_d(st_d[s-1]),
      .o_sb(st_sb[s]),   .o_rem(st_rem[s]),   .o_q(st_q[s]),   .o_d(st_d[s])
    );
  end

  // named taps of the last recurrence stage
  logic          tail_v;
  logic [DW-1:0] tail_rem, tail_q, tail_d;
  assign tail_v   = st_sb[NSTG][SB_V];
  assign tail_rem = st_rem[NSTG];
  assign tail_q   = st_q[NSTG];
  assign tail_d   = st_d[NSTG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_core  <= div_pkg::CORE_A;
      res_tag   <= '0;
      res_quot  <= '0;
      res_rem   <= '0;
    end else begin
      res_valid <= tail_v;
      res_core  <= st_sb[NSTG][SB_C];
      res_tag   <= st_sb[NSTG][SB_T -: TW];
      res_quot  <= fix_quot(tail_q, st_sb[NSTG][2], st_sb[NSTG][0]);
      res_rem   <= magnitude(tail_rem, st_sb[NSTG][1]);
    end
  end
endmodule

// File: rtl/div_shared_chk.sv
module div_shared_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    iss,
  input logic [1:0]    hold_v,
  input logic          res_valid,
  input logic          res_core,
  input logic          tail_v,
  input logic [DW-1:0] tail_rem,
  input logic [DW-1:0] tail_q,
  input logic [DW-1:0] tail_d
);
  AST_WAIT_ONE_A: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v[0] && $past(hold_v[0]) && !$past(iss[0]) |-> iss[0]); // R8
  AST_WAIT_ONE_B: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v[1] && $past(hold_v[1]) && !$past(iss[1]) |-> iss[1]); // R8
  AST_RES_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && $past(res_valid) |-> res_core != $past(res_core)); // R7
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tail_v && tail_d != '0 |-> tail_rem < tail_d); // R1
  AST_DZ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    tail_v && tail_d == '0 |-> &tail_q); // R3
endmodule

bind div_shared_top div_shared_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss(iss), .hold_v(hold_v),
  .res_valid(res_valid), .res_core(res_core),
  .tail_v(tail_v), .tail_rem(tail_rem), .tail_q(tail_q), .tail_d(tail_d)
);

// File: tb/sim_div_shared_top.sv
`timescale 1ns/1ps
module sim_div_shared_top;
  localparam int DW = 32;
  localparam int TW = 4;
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          rv [2];
  logic          rs [2];
  logic [DW-1:0] rn [2];
  logic [DW-1:0] rd [2];
  logic [TW-1:0] rt [2];
  logic          a_ready, b_ready, res_valid, res_core;
  logic [TW-1:0] res_tag;
  logic [DW-1:0] res_quot, res_rem;

  div_shared_top #(.DW(DW), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_valid(rv[0]), .a_ready(a_ready), .a_dividend(rn[0]), .a_divisor(rd[0]),
    .a_signed(rs[0]), .a_tag(rt[0]),
    .b_valid(rv[1]), .b_ready(b_ready), .b_dividend(rn[1]), .b_divisor(rd[1]),
    .b_signed(rs[1]), .b_tag(rt[1]),
    .res_valid(res_valid), .res_core(res_core), .res_tag(res_tag),
    .res_quot(res_quot), .res_rem(res_rem)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed {
    logic [2:0]    kind;
    logic [TW-1:0] tag;
    logic [DW-1:0] q;
    logic [DW-1:0] r;
    logic [31:0]   acc;
  } exp_t;
  exp_t qa [$];
  exp_t qb [$];
  int lat_tab [2][2];
  int out_par [2];

  function automatic string rname(input logic [2:0] k);
    case (k)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3";
      default: return "R4";
    endcase
  endfunction

  // reference model written from the requirements: {kind, quotient, remainder}
  function automatic logic [2*DW+2:0] model(input logic [DW-1:0] n,
                                            input logic [DW-1:0] d,
                                            input logic sg);
    longint sn, sd, sq, sr;
    if (d == '0) return {3'd3, {DW{1'b1}}, n};
    if (!sg) return {3'd1, n / d, n % d};
    if (n == MINV && d == '1) return {3'd4, MINV, {DW{1'b0}}};
    sn = longint'($signed(n));
    sd = longint'($signed(d));
    sq = sn / sd;
    sr = sn - sq * sd;
    return {3'd2, sq[DW-1:0], sr[DW-1:0]};
  endfunction

  function automatic logic rdy(input int c);
    return (c == 0) ? a_ready : b_ready;
  endfunction

  task automatic send(input int c, input logic [DW-1:0] n, input logic [DW-1:0] d,
                      input logic sg, input logic [TW-1:0] tg, output int acc);
    exp_t e;
    logic [2*DW+2:0] m;
    rv[c] = 1'b1; rn[c] = n; rd[c] = d; rs[c] = sg; rt[c] = tg;
    while (!rdy(c)) @(negedge clk);
    acc = cyc + 1;
    m = model(n, d, sg);
    e.kind = m[2*DW+2 -: 3]; e.q = m[2*DW-1 -: DW]; e.r = m[DW-1:0];
    e.tag = tg; e.acc = acc;
    if (c == 0) qa.push_back(e); else qb.push_back(e);
    @(negedge clk);
    rv[c] = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      exp_t e;
      int c, lat;
      logic ok;
      c = int'(res_core);
      ok = (c == 0) ? (qa.size() > 0) : (qb.size() > 0);
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL R5 unexpected result core=%0d tag=%0d expected none", c, res_tag);
      end else begin
        e = (c == 0) ? qa.pop_front() : qb.pop_front();
        checks++;
        if (res_tag !== e.tag || res_quot !== e.q || res_rem !== e.r) begin
          errors++;
          $display("FAIL %s R5 core=%0d got tag=%0d q=%h r=%h expected tag=%0d q=%h r=%h",
                   rname(e.kind), c, res_tag, res_quot, res_rem, e.tag, e.q, e.r);
        end
        lat = cyc - int'(e.acc);
        checks++;
        if (lat != 18 && lat != 19) begin
          errors++;
          $display("FAIL R6 latency core=%0d got %0d expected 18 or 19", c, lat);
        end else if (lat_tab[c][e.acc % 2] < 0) begin
          lat_tab[c][e.acc % 2] = lat;
        end else if (lat_tab[c][e.acc % 2] != lat) begin
          errors++;
          $display("FAIL R6 latency drift core=%0d got %0d expected %0d",
                   c, lat, lat_tab[c][e.acc % 2]);
        end
        checks++;
        if (out_par[c] < 0) out_par[c] = cyc % 2;
        if (out_par[c] != cyc % 2 || (out_par[1-c] >= 0 && out_par[1-c] == cyc % 2)) begin
          errors++;
          $display("FAIL R7 core=%0d result parity got %0d expected %0d", c, cyc % 2, out_par[c]);
        end
      end
    end
  end

  task automatic random_stream(input int c, input int count);
    int acc;
    logic [DW-1:0] n, d;
    for (int i = 0; i < count; i++) begin
      n = $urandom();
      case ($urandom_range(0, 7))
        0: d = '0;
        1, 2: d = DW'($urandom_range(1, 15));
        3: d = -DW'($urandom_range(1, 15));
        4: d = (i % 2) ? MINV : '1;
        default: d = $urandom();
      endcase
      if ($urandom_range(0, 15) == 0) n = MINV;
      send(c, n, d, 1'($urandom()), TW'(i), acc);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
  endtask

  task automatic run_all;
    int acc, prev;
    // R9 reset state
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin errors++; $display("FAIL R9 res_valid got %b expected 0", res_valid); end
    checks++;
    if (a_ready !== 1'b1 || b_ready !== 1'b1) begin
      errors++; $display("FAIL R9 ready got %b%b expected 11", a_ready, b_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || a_ready !== 1'b1 || b_ready !== 1'b1) begin
      errors++; $display("FAIL R9 after release got v=%b ready=%b%b expected 0 11", res_valid, a_ready, b_ready);
    end
    // directed corner cases, R1..R4
    send(0, 32'd100, 32'd7, 1'b0, 4'd1, acc);           // R1
    send(0, 32'hFFFF_FFFF, 32'd1, 1'b0, 4'd2, acc);     // R1
    send(1, MINV, 32'hFFFF_FFFF, 1'b0, 4'd3, acc);      // R1 unsigned top bit
    send(1, 32'd3, 32'd10, 1'b0, 4'd4, acc);            // R1
    send(0, -32'sd7, 32'd2, 1'b1, 4'd5, acc);           // R2
    send(1, 32'd7, -32'sd2, 1'b1, 4'd6, acc);           // R2
    send(0, -32'sd9, -32'sd4, 1'b1, 4'd7, acc);         // R2
    send(0, 32'd5, 32'd0, 1'b0, 4'd8, acc);             // R3 unsigned
    send(1, -32'sd9, 32'd0, 1'b1, 4'd9, acc);           // R3 signed
    send(0, MINV, 32'hFFFF_FFFF, 1'b1, 4'd10, acc);     // R4
    repeat (25) @(negedge clk);
    // R8 back-to-back burst from core a
    prev = -1;
    for (int i = 0; i < 6; i++) begin
      send(0, 32'd1000 + i, 32'd3, 1'b0, TW'(i), acc);
      if (prev >= 0) begin
        checks++;
        if ((i >= 2 && acc - prev != 2) || acc - prev > 2) begin
          errors++; $display("FAIL R8 accept spacing got %0d expected 2", acc - prev);
        end
      end
      prev = acc;
      rv[0] = 1'b1;
    end
    rv[0] = 1'b0;
    repeat (25) @(negedge clk);
    // random traffic on both cores, R1..R7
    fork
      random_stream(0, 300);
      random_stream(1, 300);
    join
    repeat (30) @(negedge clk);
    checks++;
    if (qa.size() != 0 || qb.size() != 0) begin
      errors++; $display("FAIL R5 outstanding got %0d expected 0", qa.size() + qb.size());
    end
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      rv[c] = 1'b0; rs[c] = 1'b0; rn[c] = '0; rd[c] = '0; rt[c] = '0;
      out_par[c] = -1;
      for (int p = 0; p < 2; p++) lat_tab[c][p] = -1;
    end
    void'($urandom(32'd1234));
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule